// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block observes every bus cycle. A cycle carries an address, an access size, a direction, a cycle type, a bus-master tag and a 32-bit data value. The block compares each cycle against two programmable break channels. Each channel holds a break address, an address mask and a control word. The control word selects a size condition and filters on cycle type, direction and bus master. The second channel also holds a data value and a data mask, and it can require a data match in addition to the address match.

The address comparison follows the access size. A longword access matches on address bits 31..2, a word access on bits 31..1 and a byte access on all bits. A break address that points at a byte therefore also matches a longword or word access that covers that byte. Results appear one clock after the cycle as a per-channel pulse. The same result also sets a per-channel sticky flag, which software clears through the write port.

Registers are written through a simple synchronous write port. Register index: 0 ch0 address, 1 ch0 address mask, 2 ch0 control, 3 ch1 address, 4 ch1 address mask, 5 ch1 control, 6 ch1 data, 7 ch1 data mask, 8 flag clear (bit0 clears ch0, bit1 clears ch1).

Control word fields:

| Bits | Field | Values |
|------|-------|--------|
| 0 | Enable | 1 enables the channel |
| 2:1 | Cycle type | 1 fetch only, 2 data only, 0 or 3 either |
| 4:3 | Direction | 1 read only, 2 write only, 0 or 3 either |
| 6:5 | Master | 1 CPU only, 2 DMA only, 0 or 3 either |
| 8:7 | Size condition | 0 none, 1 byte, 2 word, 3 longword |
| 9 | Data condition | 1 enables it, on ch1 only |

The bus size encoding is 0 byte, 1 word and 2 longword.

Top module: `bus_break_cmp`

## Requirements
- R1: A longword cycle (size 2) compares only address bits 31..2 with the break address, so break address 0x1003 matches a longword at 0x1000 and does not match one at 0x1004.
- R2: A word cycle (size 1) compares address bits 31..1, so break address 0x1003 matches a word at 0x1002 and does not match one at 0x1000.
- R3: A byte cycle (size 0) compares all 32 address bits, so break address 0x1003 matches a byte at 0x1003 and does not match one at 0x1002.
- R4: A set bit in the address mask removes that address bit from the comparison.
- R5: A nonzero size condition (control bits 8:7) matches only cycles whose size code plus one equals it. Size condition 0 accepts every size.
- R6: The type, direction and master fields (control bits 2:1, 4:3 and 6:5) each restrict the match to fetch or data cycles, read or write cycles, and CPU or DMA cycles. Field values 0 and 3 accept both.
- R7: When ch1 has control bit 9 set, it matches only if the address condition and the data condition both hold. Set data-mask bits are excluded from the data comparison. If the size condition is not longword, data bits 31..16 are ignored.
- R8: When the ch1 cycle-type field selects fetch only (value 1), the data value register is ignored and the match depends on the address alone.
- R9: `cfg_err` goes high, two clocks after the write that causes it, while ch1 is enabled with the data condition set, the size condition set to longword, and a master field that admits DMA (0, 2 or 3).
- R10: Each channel sets its sticky flag when it matches. The flag stays set until a write to index 8 with the matching bit set. A channel whose enable bit is 0 never matches.
- R11: `brk_hit` is registered: a cycle presented with `bus_valid` high at a clock edge produces its result after that edge. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_dma | input | 1 | 1 when the DMA controller masters the cycle |
| bus_data | input | 32 | Cycle data value |
| brk_hit | output | 2 | Per-channel match pulse, one clock after the cycle |
| brk_sticky | output | 2 | Per-channel sticky match flags |
| cfg_err | output | 1 | Illegal ch1 data/size/master combination |

## Verification
The assertions check the bookkeeping on every cycle:
- an idle bus produces no hit;
- a disabled channel never hits;
- a hit always leaves its sticky flag set;
- a flag only drops after a clear write;
- the error flag is only raised from a longword data condition.

Only the bench's scenarios can show that the comparison itself is right. These scenarios cover the size-dependent address narrowing at 0x1003, the mask exclusion, the filters, the 16-bit data lane for byte and word conditions, and the fetch case that ignores data.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CTRL_W = 10;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
  localparam logic [1:0] SC_LONG = 2'd3;
  localparam logic [3:0] IX_A0 = 4'd0, IX_M0 = 4'd1, IX_C0 = 4'd2;
  localparam logic [3:0] IX_A1 = 4'd3, IX_M1 = 4'd4, IX_C1 = 4'd5;
  localparam logic [3:0] IX_D1 = 4'd6, IX_DM1 = 4'd7, IX_CLR = 4'd8;
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic [AW-1:0]     ref_addr,
  input  logic [AW-1:0]     addr_mask,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DW-1:0]     ref_data,
  input  logic [DW-1:0]     data_mask,
  input  logic              bus_valid,
  input  logic [AW-1:0]     bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_write,
  input  logic              bus_fetch,
  input  logic              bus_dma,
  input  logic [DW-1:0]     bus_data,
  output logic              hit_now
);
  localparam int HALF = DW / 2;

  logic [1:0]    tsel, dsel, msel, scond;
  logic          den, type_ok, dir_ok, mst_ok, size_ok, addr_ok, data_ok;
  logic [AW-1:0] low_ign, a_care;
  logic [DW-1:0] d_care;

  always_comb begin
    tsel  = ctrl[2:1];
    dsel  = ctrl[4:3];
    msel  = ctrl[6:5];
    scond = ctrl[8:7];
    den   = HAS_DATA && ctrl[9];
    type_ok = (tsel == 2'd1) ? bus_fetch : (tsel == 2'd2) ? !bus_fetch : 1'b1;
    dir_ok  = (dsel == 2'd1) ? !bus_write : (dsel == 2'd2) ? bus_write : 1'b1;
    mst_ok  = (msel == 2'd1) ? !bus_dma : (msel == 2'd2) ? bus_dma : 1'b1;
    size_ok = (scond == 2'd0) || (scond == bus_size + 2'd1);
    // address narrowing by access size
    low_ign = '0;
    if (bus_size == SZ_LONG) low_ign[1:0] = 2'b11;
    else if (bus_size == SZ_WORD) low_ign[0] = 1'b1;
    a_care  = ~(addr_mask | low_ign);
    addr_ok = ((bus_addr ^ ref_addr) & a_care) == '0;
    // data lane: only the lower half unless a longword condition is set
    d_care = ~data_mask;
    if (scond != SC_LONG) d_care[DW-1:HALF] = '0;
    data_ok = !den || (tsel == 2'd1) || (((bus_data ^ ref_data) & d_care) == '0);
    hit_now = bus_valid && ctrl[0] && type_ok && dir_ok && mst_ok &&
              size_ok && addr_ok && data_ok;
  end
endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [3:0]     cfg_idx,
  input  logic [31:0]    cfg_wdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [1:0]     bus_size,
  input  logic           bus_write,
  input  logic           bus_fetch,
  input  logic           bus_dma,
  input  logic [DW-1:0]  bus_data,
  output logic [NCH-1:0] brk_hit,
  output logic [NCH-1:0] brk_sticky,
  output logic           cfg_err
);
  logic [AW-1:0]     a_reg [NCH];
  logic [AW-1:0]     m_reg [NCH];
  logic [CTRL_W-1:0] c_reg [NCH];
  logic [DW-1:0]     d_reg, dm_reg;
  logic [NCH-1:0]    hit_now, clr;
  logic              err_now;

  assign clr = (cfg_we && cfg_idx == IX_CLR) ? cfg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        a_reg[i] <= '0;
        m_reg[i] <= '0;
        c_reg[i] <= '0;
      end
      d_reg  <= '0;
      dm_reg <= '0;
    end else if (cfg_we) begin
      case (cfg_idx)
        IX_A0:  a_reg[0] <= cfg_wdata[AW-1:0];
        IX_M0:  m_reg[0] <= cfg_wdata[AW-1:0];
        IX_C0:  c_reg[0] <= cfg_wdata[CTRL_W-1:0];
        IX_A1:  a_reg[1] <= cfg_wdata[AW-1:0];
        IX_M1:  m_reg[1] <= cfg_wdata[AW-1:0];
        IX_C1:  c_reg[1] <= cfg_wdata[CTRL_W-1:0];
        IX_D1:  d_reg    <= cfg_wdata[DW-1:0];
        IX_DM1: dm_reg   <= cfg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    brk_chan #(.AW(AW), .DW(DW), .HAS_DATA(g == 1)) u_chan (
      .ref_addr(a_reg[g]), .addr_mask(m_reg[g]), .ctrl(c_reg[g]),
      .ref_data(d_reg), .data_mask(dm_reg),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_write(bus_write), .bus_fetch(bus_fetch), .bus_dma(bus_dma),
      .bus_data(bus_data), .hit_now(hit_now[g])
    );
  end

  // R9: longword data condition where DMA may master the cycle
  assign err_now = c_reg[1][0] && c_reg[1][9] && (c_reg[1][8:7] == SC_LONG) &&
                   (c_reg[1][6:5] != 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_hit    <= '0;
      brk_sticky <= '0;
      cfg_err    <= 1'b0;
    end else begin
      brk_hit    <= hit_now;
      brk_sticky <= (brk_sticky & ~clr) | hit_now;
      cfg_err    <= err_now;
    end
  end

  a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> brk_hit == '0);
  a_r10_off_ch0_quiet: assert property (@(posedge clk) disable iff (rst)
    !c_reg[0][0] |=> !brk_hit[0]);
  a_r10_off_ch1_quiet: assert property (@(posedge clk) disable iff (rst)
    !c_reg[1][0] |=> !brk_hit[1]);
  a_r10_hit_sets_flag0: assert property (@(posedge clk) disable iff (rst)
    brk_hit[0] |-> brk_sticky[0]);
  a_r10_hit_sets_flag1: assert property (@(posedge clk) disable iff (rst)
    brk_hit[1] |-> brk_sticky[1]);
  a_r10_flag0_holds: assert property (@(posedge clk) disable iff (rst)
    (brk_sticky[0] && !(cfg_we && cfg_idx == IX_CLR && cfg_wdata[0])) |=> brk_sticky[0]);
  a_r10_flag1_holds: assert property (@(posedge clk) disable iff (rst)
    (brk_sticky[1] && !(cfg_we && cfg_idx == IX_CLR && cfg_wdata[1])) |=> brk_sticky[1]);
  a_r9_err_needs_long: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(c_reg[1][8:7]) == SC_LONG);
endmodule

// File: tb/bus_break_cmp_test.sv
module bus_break_cmp_test;
  logic        clk = 0, rst = 1;
  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic        bus_valid = 0, bus_write = 0, bus_fetch = 0, bus_dma = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic [1:0]  bus_size = 0;
  logic [1:0]  brk_hit, brk_sticky;
  logic        cfg_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_break_cmp uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [1:0] sz, input logic w,
                     input logic f, input logic dm, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; bus_size = sz; bus_write = w;
    bus_fetch = f; bus_dma = dm; bus_data = d;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic t_reset;
    check("R11 reset hit", brk_hit, 0);
    check("R11 reset sticky", brk_sticky, 0);
    check("R11 reset err", cfg_err, 0);
  endtask

  task automatic t_size_narrow;
    wr(0, 32'h1003); wr(1, 0); wr(2, 32'h001);
    cyc(32'h1000, 2, 0, 0, 0, 0); check("R1 long 1000", brk_hit, 2'b01);
    cyc(32'h1004, 2, 0, 0, 0, 0); check("R1 long 1004", brk_hit, 2'b00);
    cyc(32'h1002, 1, 0, 0, 0, 0); check("R2 word 1002", brk_hit, 2'b01);
    cyc(32'h1000, 1, 0, 0, 0, 0); check("R2 word 1000", brk_hit, 2'b00);
    cyc(32'h1003, 0, 0, 0, 0, 0); check("R3 byte 1003", brk_hit, 2'b01);
    cyc(32'h1002, 0, 0, 0, 0, 0); check("R3 byte 1002", brk_hit, 2'b00);
  endtask

  task automatic t_mask;
    wr(1, 32'h0000_00F0);
    cyc(32'h10F3, 0, 0, 0, 0, 0); check("R4 masked bits", brk_hit, 2'b01);
    cyc(32'h1103, 0, 0, 0, 0, 0); check("R4 unmasked bit", brk_hit, 2'b00);
    wr(1, 0);
  endtask

  task automatic t_size_cond;
    wr(2, 32'h081);
    cyc(32'h1000, 2, 0, 0, 0, 0); check("R5 long rejected", brk_hit, 2'b00);
    cyc(32'h1003, 0, 0, 0, 0, 0); check("R5 byte accepted", brk_hit, 2'b01);
  endtask

  task automatic t_filters;
    wr(2, 32'h053);
    cyc(32'h1003, 0, 1, 1, 1, 0); check("R6 all filters met", brk_hit, 2'b01);
    cyc(32'h1003, 0, 0, 1, 1, 0); check("R6 read rejected", brk_hit, 2'b00);
    cyc(32'h1003, 0, 1, 0, 1, 0); check("R6 data rejected", brk_hit, 2'b00);
    cyc(32'h1003, 0, 1, 1, 0, 0); check("R6 cpu rejected", brk_hit, 2'b00);
  endtask

  task automatic t_data;
    wr(2, 0);
    wr(3, 32'h2000); wr(4, 0); wr(6, 32'h0000_ABAB); wr(7, 0); wr(5, 32'h285);
    cyc(32'h2000, 0, 0, 0, 0, 32'hFFFF_ABAB); check("R7 byte upper ignored", brk_hit, 2'b10);
    cyc(32'h2000, 0, 0, 0, 0, 32'h0000_AB00); check("R7 data mismatch", brk_hit, 2'b00);
    cyc(32'h2001, 0, 0, 0, 0, 32'h0000_ABAB); check("R7 addr mismatch", brk_hit, 2'b00);
    wr(7, 32'h0000_00FF);
    cyc(32'h2000, 0, 0, 0, 0, 32'h0000_AB00); check("R7 data mask", brk_hit, 2'b10);
    wr(7, 0);
    wr(6, 32'h1234_5678); wr(5, 32'h385);
    cyc(32'h2000, 2, 0, 0, 0, 32'h1234_5678); check("R7 long data match", brk_hit, 2'b10);
    cyc(32'h2000, 2, 0, 0, 0, 32'h9234_5678); check("R7 long upper compared", brk_hit, 2'b00);
  endtask

  task automatic t_fetch;
    wr(5, 32'h203);
    cyc(32'h2000, 2, 0, 1, 0, 32'h0); check("R8 fetch ignores data", brk_hit, 2'b10);
  endtask

  task automatic t_err;
    wr(5, 32'h385); @(negedge clk); check("R9 either master long", cfg_err, 1);
    wr(5, 32'h3A5); @(negedge clk); check("R9 cpu only long", cfg_err, 0);
    wr(5, 32'h3C5); @(negedge clk); check("R9 dma only long", cfg_err, 1);
    wr(5, 32'h345); @(negedge clk); check("R9 dma word", cfg_err, 0);
  endtask

  task automatic t_sticky;
    check("R10 sticky both set", brk_sticky, 2'b11);
    wr(8, 32'h1);
    check("R10 clear ch0 only", brk_sticky, 2'b10);
    wr(8, 32'h2);
    check("R10 clear ch1", brk_sticky, 2'b00);
    wr(2, 32'h000);
    cyc(32'h1003, 0, 0, 0, 0, 0);
    check("R10 disabled no hit", brk_hit, 2'b00);
    check("R10 disabled no flag", brk_sticky, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_size_narrow();
    t_mask();
    t_size_cond();
    t_filters();
    t_data();
    t_fetch();
    t_err();
    t_sticky();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule